// File: doc/BRIEF.md
# CAN Interrupt Request Flag Register

This block keeps two interrupt status bits for a CAN controller and combines them into one interrupt request line. The first bit reports that a transmit mailbox has become free. It is not stored. Each cycle it is recomputed from the per-mailbox transmit-acknowledge and abort-acknowledge vectors, and only mailboxes whose mask bit is 0 count. Software cannot write it. The bit falls on its own when the acknowledge logic clears the last acknowledge. It also falls when software masks every mailbox that still holds an acknowledge.

The second bit records that the controller saw a condition that calls for an overload frame. It is sticky and is cleared by writing 1 to its position. It sets even when the controller may not transmit, for example in listen-only mode. In that mode the separate overload-frame request output stays low. All outputs come straight from registers, so each output follows its inputs one clock later. Reset is synchronous and active high.

Top module: `can_irq_flags`

## Requirements
- R1: One clock after inputs are applied, `mbx_empty` is 1 exactly when at least one mailbox i has (`tx_ack[i]` or `abort_ack[i]`) = 1 while `mbx_mask[i]` = 0. The mailbox count is the parameter `N_MBOX`, 16 by default.
- R2: When every bit of `tx_ack` and `abort_ack` is 0, `mbx_empty` is 0 one clock later.
- R3: When `mbx_mask` is set for every mailbox that has an acknowledge or abort bit set, `mbx_empty` is 0 one clock later, even though the acknowledges remain.
- R4: A write (`wr_en` = 1) with any value of `wr_data`, including 1 in bit 8 (the mailbox-empty position), has no effect on `mbx_empty`.
- R5: When `ovld_det` is 1 in a cycle, `ovld_flag` is 1 one clock later, whatever the value of `listen_only`.
- R6: `ovld_flag` stays set until a write with `wr_data` bit 7 = 1 clears it, one clock later. A write with bit 7 = 0 leaves it unchanged.
- R7: If `ovld_det` = 1 and a write with bit 7 = 1 occur in the same cycle, `ovld_flag` is 1 one clock later.
- R8: While `rst` is high, at every clock all outputs become 0.
- R9: `irq` is 1 exactly when `mbx_empty` or `ovld_flag` is 1. `rd_data` carries `ovld_flag` in bit 7 and `mbx_empty` in bit 8, and every other bit of `rd_data` reads 0.
- R10: One clock after a cycle, `ovld_frame_req` equals `ovld_det` AND NOT `listen_only` of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ack | input | N_MBOX | Per-mailbox transmit-acknowledge bits |
| abort_ack | input | N_MBOX | Per-mailbox abort-acknowledge bits |
| mbx_mask | input | N_MBOX | Per-mailbox interrupt mask, 1 = excluded |
| ovld_det | input | 1 | Pulse: an overload condition was detected |
| listen_only | input | 1 | Transmission inhibited |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| mbx_empty | output | 1 | Mailbox-empty flag |
| ovld_flag | output | 1 | Sticky overload flag |
| irq | output | 1 | Combined interrupt request |
| ovld_frame_req | output | 1 | Request to send an overload frame |
| rd_data | output | REG_W | Register read value |

## Verification
The case that is hardest to reach from the ports is the overload flag under a collision of a detect pulse and a clearing write, applied from both previous flag states. The bench first forces a known previous state: it pulses the detector to set the flag, or writes 1 to bit 7 to clear it. It then applies every combination of detect, write strobe, bit 7 and listen-only in one cycle. For the mailbox-empty flag, the bench sweeps every acknowledge, abort and mask pattern of a four-mailbox configuration. Alongside the sweep it issues writes with bit 8 set, which shows that this position cannot be written.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned OVLD_POS = 7;
  localparam int unsigned MBX_POS  = 8;
  localparam int unsigned MIN_REG_W = MBX_POS + 1;

  typedef struct packed {
    logic mbx;
    logic ovld;
  } flag_pair_t;
endpackage

// File: rtl/mbx_empty_reduce.sv
module mbx_empty_reduce #(
  parameter int unsigned N_MBOX = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MBOX-1:0] tx_ack,
  input  logic [N_MBOX-1:0] abort_ack,
  input  logic [N_MBOX-1:0] mbx_mask,
  output logic              empty_d,
  output logic              empty_q
);
  logic [N_MBOX-1:0] live;

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mbx
    assign live[i] = (tx_ack[i] | abort_ack[i]) & ~mbx_mask[i];
  end

  assign empty_d = |live;

  always_ff @(posedge clk) begin
    if (rst) empty_q <= 1'b0;
    else     empty_q <= empty_d;
  end

  assert_unmasked_tx_sets_R1: assert property (@(posedge clk) disable iff (rst)
    ((tx_ack & ~mbx_mask) != '0) |=> empty_q);
  assert_no_ack_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_ack == '0 && abort_ack == '0) |=> !empty_q);
  assert_full_mask_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (&mbx_mask) |=> !empty_q);
endmodule

// File: rtl/ovld_flag.sv
module ovld_flag (
  input  logic clk,
  input  logic rst,
  input  logic det,
  input  logic listen_only,
  input  logic clr_req,
  output logic flag_d,
  output logic flag_q,
  output logic frame_req_q
);
  assign flag_d = det | (flag_q & ~clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q      <= 1'b0;
      frame_req_q <= 1'b0;
    end else begin
      flag_q      <= flag_d;
      frame_req_q <= det & ~listen_only;
    end
  end

  assert_det_sets_R5: assert property (@(posedge clk) disable iff (rst)
    det |=> flag_q);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (!det && !clr_req) |=> $stable(flag_q));
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!det && clr_req) |=> !flag_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (det && clr_req) |=> flag_q);
  assert_frame_req_R10: assert property (@(posedge clk) disable iff (rst)
    (det && listen_only) |=> !frame_req_q);
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import can_irq_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  flag_pair_t       next_flags,
  input  flag_pair_t       cur_flags,
  output logic             irq_q,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= next_flags.mbx | next_flags.ovld;
  end

  always_comb begin
    rd_data           = '0;
    rd_data[OVLD_POS] = cur_flags.ovld;
    rd_data[MBX_POS]  = cur_flags.mbx;
  end

  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == (cur_flags.mbx | cur_flags.ovld));
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int unsigned N_MBOX = 16,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MBOX-1:0] tx_ack,
  input  logic [N_MBOX-1:0] abort_ack,
  input  logic [N_MBOX-1:0] mbx_mask,
  input  logic              ovld_det,
  input  logic              listen_only,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic              mbx_empty,
  output logic              ovld_flag,
  output logic              irq,
  output logic              ovld_frame_req,
  output logic [REG_W-1:0]  rd_data
);
  logic       mbx_d;
  logic       ovld_d;
  logic       clr_req;
  flag_pair_t next_flags;
  flag_pair_t cur_flags;

  assign clr_req = wr_en & wr_data[OVLD_POS];

  mbx_empty_reduce #(.N_MBOX(N_MBOX)) i_reduce (
    .clk      (clk),
    .rst      (rst),
    .tx_ack   (tx_ack),
    .abort_ack(abort_ack),
    .mbx_mask (mbx_mask),
    .empty_d  (mbx_d),
    .empty_q  (mbx_empty)
  );

  ovld_flag i_ovld (
    .clk        (clk),
    .rst        (rst),
    .det        (ovld_det),
    .listen_only(listen_only),
    .clr_req    (clr_req),
    .flag_d     (ovld_d),
    .flag_q     (ovld_flag),
    .frame_req_q(ovld_frame_req)
  );

  assign next_flags = '{mbx: mbx_d, ovld: ovld_d};
  assign cur_flags  = '{mbx: mbx_empty, ovld: ovld_flag};

  irq_readback #(.REG_W(REG_W)) i_rb (
    .clk       (clk),
    .rst       (rst),
    .next_flags(next_flags),
    .cur_flags (cur_flags),
    .irq_q     (irq),
    .rd_data   (rd_data)
  );

  initial begin
    assert_reg_width_R9: assert (REG_W >= MIN_REG_W);
  end

  assert_write_cannot_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data != '0 && tx_ack == '0 && abort_ack == '0) |=> !mbx_empty);
  assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[OVLD_POS] && !ovld_det) |=> $stable(ovld_flag));
endmodule

// File: tb/test_can_irq_flags.sv
module test_can_irq_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NM-1:0] tx_ack, abort_ack, mbx_mask;
  logic          ovld_det, listen_only, wr_en;
  logic [RW-1:0] wr_data;
  logic          mbx_empty, ovld_flag, irq, ovld_frame_req;
  logic [RW-1:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_flags #(.N_MBOX(NM), .REG_W(RW)) i_can_irq_flags (
    .clk(clk), .rst(rst), .tx_ack(tx_ack), .abort_ack(abort_ack),
    .mbx_mask(mbx_mask), .ovld_det(ovld_det), .listen_only(listen_only),
    .wr_en(wr_en), .wr_data(wr_data), .mbx_empty(mbx_empty),
    .ovld_flag(ovld_flag), .irq(irq), .ovld_frame_req(ovld_frame_req),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    tx_ack = '0; abort_ack = '0; mbx_mask = '0;
    ovld_det = 1'b0; listen_only = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic exp_mbx(input logic [NM-1:0] t, input logic [NM-1:0] a,
                                   input logic [NM-1:0] m);
    logic r = 1'b0;
    for (int i = 0; i < NM; i++)
      if ((t[i] || a[i]) && !m[i]) r = 1'b1;
    return r;
  endfunction

  initial begin
    idle();
    rst = 1'b1;
    ovld_det = 1'b1;
    tx_ack = '1;
    repeat (3) @(negedge clk);
    chk("R8 mbx_empty", mbx_empty, 0);
    chk("R8 ovld_flag", ovld_flag, 0);
    chk("R8 irq", irq, 0);
    chk("R8 frame_req", ovld_frame_req, 0);
    chk("R8 rd_data", rd_data, 0);
    idle();
    rst = 1'b0;
    step();

    for (int c = 0; c < (1 << (3*NM)); c++) begin
      logic e;
      tx_ack    = c[NM-1:0];
      abort_ack = c[2*NM-1:NM];
      mbx_mask  = c[3*NM-1:2*NM];
      wr_en     = c[0] ^ c[5];
      wr_data   = 16'h0100 | 16'(c[3:0] << 9);
      e = exp_mbx(tx_ack, abort_ack, mbx_mask);
      step();
      chk(e ? "R1 mbx_empty" : "R1 R4 mbx_empty", mbx_empty, e);
      if (tx_ack == 0 && abort_ack == 0) chk("R2 mbx_empty", mbx_empty, 0);
      if (&mbx_mask) chk("R3 mbx_empty", mbx_empty, 0);
      chk("R9 irq", irq, e);
      chk("R9 rd_data", rd_data, {23'd0, e, 8'd0});
    end
    idle();
    step();

    for (int c = 0; c < 32; c++) begin
      logic prior, e;
      prior = c[4];
      if (prior) ovld_det = 1'b1;
      else begin wr_en = 1'b1; wr_data = 16'h0080; end
      step();
      idle();
      chk("R6 prior state", ovld_flag, prior);
      ovld_det    = c[0];
      wr_en       = c[1];
      wr_data     = c[2] ? 16'h0180 : 16'h0100;
      listen_only = c[3];
      e = c[0] | (prior & ~(c[1] & c[2]));
      step();
      if (c[0] && c[1] && c[2]) chk("R7 ovld_flag", ovld_flag, 1);
      else if (c[0]) chk("R5 ovld_flag", ovld_flag, 1);
      else chk("R6 ovld_flag", ovld_flag, e);
      chk("R10 frame_req", ovld_frame_req, c[0] & ~c[3]);
      chk("R9 irq ovld", irq, e);
      chk("R9 rd_data ovld", rd_data, {24'd0, e, 7'd0});
      chk("R4 mbx_empty", mbx_empty, 0);
      idle();
    end

    ovld_det = 1'b1; tx_ack = 4'b0010;
    step();
    idle();
    tx_ack = 4'b0010;
    step();
    chk("R9 rd_data both", rd_data, 32'h0180);
    chk("R9 irq both", irq, 1);
    tx_ack = '0;
    step();
    chk("R6 held after ack drop", ovld_flag, 1);
    chk("R2 drop with ovld", mbx_empty, 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule